// File: doc/BRIEF.md
# Immersion Watershed Labeling Engine

This block segments one small greyscale frame by simulated immersion. A pixel stream (data, valid, end-of-line, end-of-frame, all on one clock) fills on-chip pixel storage, and a 256-bin occupancy map records which grey values occur. The engine then floods the relief from the lowest occupied grey value upward. For each occupied value it makes one raster pass over the frame. Every pixel carrying that value is labeled from the 3x3 window around it:

- When its already-labeled neighbours all agree, the pixel inherits their label.
- When it has no labeled neighbour, it starts a fresh region.
- When its neighbours disagree, it is marked as a watershed pixel.

When the highest grey value has been handled, a one-cycle done pulse is raised. The engine then waits for a read request and streams the label map out with the same framing signals. Streaming clears the label store, so the next frame starts clean. Typical use is after binarization or gradient stages in an inspection pipeline, where the label map separates touching objects.

Top module: `wshed_engine`

## Requirements
- R1: Input pixels are stored row-major. A valid pixel with in_eol moves the write position to column 0 of the next row, and a valid pixel with in_eof ends loading.
- R2: Grey values are processed lowest first, each in a full raster pass before the next value starts. Every pixel receives its label exactly once.
- R3: Grey values with no pixel cost one cycle each. From end of load to done takes at most (distinct values x 2500) + 260 cycles.
- R4: A pixel whose labeled neighbours all carry the same region label takes that label.
- R5: A pixel with no labeled neighbour gets a new region label. New labels are handed out as 1, 2, 3, … in processing order, and 0 means unlabeled.
- R6: A pixel whose labeled neighbours carry two or more different region labels gets the watershed code 0xFFF. Neighbours already holding 0xFFF are ignored in that comparison.
- R7: The neighbourhood is the eight pixels of the 3x3 window, diagonals included. Positions outside the 50x50 frame count as unlabeled, and rows do not wrap.
- R8: done is a single-cycle pulse after the last grey value. No output is valid before rd_req is asserted.
- R9: After rd_req, 2500 consecutive valid labels are streamed row-major. out_eol is high on every 50th one, and out_eof is high on the last.
- R10: After a frame has been read out, a new frame can be loaded, and its labels again start at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_data | input | 8 | Grey value |
| in_eol | input | 1 | Last pixel of a row |
| in_eof | input | 1 | Last pixel of the frame |
| rd_req | input | 1 | Start streaming the label map |
| done | output | 1 | Labeling finished (one-cycle pulse) |
| out_valid | output | 1 | Output label qualifier |
| out_label | output | 12 | Label: 0 unlabeled, 0xFFF watershed, otherwise region |
| out_eol | output | 1 | Last label of a row |
| out_eof | output | 1 | Last label of the frame |

## Verification
The hardest situation to reach from the ports is a pixel that sits between two basins grown at lower grey levels, because it only arises after several earlier levels have each been flooded correctly. The bench creates it with a two-valley ramp frame whose ridge column must turn into watershed pixels. A frame of isolated low points checks diagonal joining and the absence of row wrap. A random three-level frame produces many fresh labels and watershed pixels. Each expected label map comes from an independent immersion model in the bench.

// File: rtl/wshed_pkg.sv
package wshed_pkg;
    typedef enum logic [2:0] {S_LOAD, S_SEEK, S_PASS, S_WAIT, S_STREAM} state_t;
    typedef enum logic [1:0] {D_TAKE, D_NEW, D_SHED} dec_t;
endpackage

// File: rtl/wshed_occ.sv
module wshed_occ #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [PIX_W-1:0] set_lvl,
    input  logic             clr,
    input  logic [PIX_W-1:0] query_lvl,
    output logic             hit
);
    localparam int NLVL = 1 << PIX_W;

    logic [NLVL-1:0] occ_d, occ_q;

    always_comb begin
        occ_d = occ_q;
        if (clr) occ_d = '0;
        else if (set_en) occ_d[set_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign hit = occ_q[query_lvl];
endmodule

// File: rtl/wshed_decide.sv
module wshed_decide
    import wshed_pkg::*;
#(
    parameter int LBL_W = 12,
    parameter int NNB   = 8
) (
    input  logic [NNB-1:0][LBL_W-1:0] nb_lbl,
    input  logic [NNB-1:0]            nb_in,
    output dec_t                      dec,
    output logic [LBL_W-1:0]          lbl
);
    localparam logic [LBL_W-1:0] SHED = '1;

    logic [NNB-1:0] usable;

    for (genvar k = 0; k < NNB; k++) begin : g_use
        assign usable[k] = nb_in[k] && (nb_lbl[k] != '0) && (nb_lbl[k] != SHED);
    end

    always_comb begin
        logic             found;
        logic             differ;
        logic [LBL_W-1:0] first;
        found  = 1'b0;
        differ = 1'b0;
        first  = '0;
        for (int k = 0; k < NNB; k++) begin
            if (usable[k]) begin
                if (!found) begin
                    found = 1'b1;
                    first = nb_lbl[k];
                end else if (nb_lbl[k] != first) begin
                    differ = 1'b1;
                end
            end
        end
        lbl = first;
        if (!found)     dec = D_NEW;
        else if (differ) dec = D_SHED;
        else            dec = D_TAKE;
    end
endmodule

// File: rtl/wshed_engine.sv
module wshed_engine
    import wshed_pkg::*;
#(
    parameter int IMG_W = 50,
    parameter int IMG_H = 50,
    parameter int PIX_W = 8,
    parameter int LBL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_eol,
    input  logic             in_eof,
    input  logic             rd_req,
    output logic             done,
    output logic             out_valid,
    output logic [LBL_W-1:0] out_label,
    output logic             out_eol,
    output logic             out_eof
);
    localparam int NPIX = IMG_W * IMG_H;
    localparam int AW   = $clog2(NPIX);
    localparam int CW   = $clog2(IMG_W);
    localparam int RW   = $clog2(IMG_H);
    localparam int NNB  = 8;
    localparam logic [LBL_W-1:0] SHED = '1;
    localparam logic [AW-1:0]    LAST = AW'(NPIX - 1);
    localparam logic [CW-1:0]    LCOL = CW'(IMG_W - 1);

    typedef struct packed {
        state_t           st;
        logic [AW-1:0]    ptr;
        logic [RW-1:0]    row;
        logic [CW-1:0]    col;
        logic [PIX_W-1:0] lvl;
        logic [LBL_W-1:0] nxt;
        logic             done;
        logic             ovld;
        logic [LBL_W-1:0] olbl;
        logic             oeol;
        logic             oeof;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PIX_W-1:0] pix_mem [NPIX];
    logic [LBL_W-1:0] lab_mem [NPIX];

    logic             pix_we;
    logic [AW-1:0]    pix_wa;
    logic             lab_we;
    logic [AW-1:0]    lab_wa;
    logic [LBL_W-1:0] lab_wd;
    logic             occ_set, occ_clr, occ_hit;

    logic [NNB-1:0][LBL_W-1:0] nb_lbl;
    logic [NNB-1:0]            nb_in;
    dec_t                      dec;
    logic [LBL_W-1:0]          dec_lbl;

    wshed_occ #(.PIX_W(PIX_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .set_en(occ_set), .set_lvl(in_data),
        .clr(occ_clr), .query_lvl(ctl_q.lvl), .hit(occ_hit)
    );

    wshed_decide #(.LBL_W(LBL_W), .NNB(NNB)) u_dec (
        .nb_lbl(nb_lbl), .nb_in(nb_in), .dec(dec), .lbl(dec_lbl)
    );

    // Gather the eight window neighbours of the pixel under the pass cursor
    always_comb begin
        for (int j = 0; j < 9; j++) begin
            int k, rr, cc;
            logic ok;
            if (j != 4) begin
                k  = (j < 4) ? j : j - 1;
                rr = int'(ctl_q.row) + (j / 3) - 1;
                cc = int'(ctl_q.col) + (j % 3) - 1;
                ok = (rr >= 0) && (rr < IMG_H) && (cc >= 0) && (cc < IMG_W);
                nb_in[k]  = ok;
                nb_lbl[k] = ok ? lab_mem[AW'(rr * IMG_W + cc)] : '0;
            end
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.ovld = 1'b0;
        ctl_d.oeol = 1'b0;
        ctl_d.oeof = 1'b0;
        pix_we  = 1'b0;
        pix_wa  = AW'(ctl_q.row) * AW'(IMG_W) + AW'(ctl_q.col);
        lab_we  = 1'b0;
        lab_wa  = ctl_q.ptr;
        lab_wd  = '0;
        occ_set = 1'b0;
        occ_clr = 1'b0;
        case (ctl_q.st)
            S_LOAD: begin
                if (in_valid) begin
                    pix_we  = (int'(ctl_q.row) < IMG_H) && (int'(ctl_q.col) < IMG_W);
                    occ_set = 1'b1;
                    if (in_eof) begin
                        ctl_d.st  = S_SEEK;
                        ctl_d.lvl = '0;
                        ctl_d.row = '0;
                        ctl_d.col = '0;
                    end else if (in_eol) begin
                        ctl_d.col = '0;
                        ctl_d.row = ctl_q.row + 1'b1;
                    end else begin
                        ctl_d.col = ctl_q.col + 1'b1;
                    end
                end
            end
            S_SEEK: begin
                if (occ_hit) begin
                    ctl_d.st  = S_PASS;
                    ctl_d.ptr = '0;
                    ctl_d.row = '0;
                    ctl_d.col = '0;
                end else if (ctl_q.lvl == '1) begin
                    ctl_d.st   = S_WAIT;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.lvl = ctl_q.lvl + 1'b1;
                end
            end
            S_PASS: begin
                if (pix_mem[ctl_q.ptr] == ctl_q.lvl) begin
                    lab_we = 1'b1;
                    case (dec)
                        D_TAKE: lab_wd = dec_lbl;
                        D_NEW: begin
                            lab_wd    = ctl_q.nxt;
                            ctl_d.nxt = ctl_q.nxt + 1'b1;
                        end
                        default: lab_wd = SHED;
                    endcase
                end
                if (ctl_q.ptr == LAST) begin
                    if (ctl_q.lvl == '1) begin
                        ctl_d.st   = S_WAIT;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st  = S_SEEK;
                        ctl_d.lvl = ctl_q.lvl + 1'b1;
                    end
                end else begin
                    ctl_d.ptr = ctl_q.ptr + 1'b1;
                    if (ctl_q.col == LCOL) begin
                        ctl_d.col = '0;
                        ctl_d.row = ctl_q.row + 1'b1;
                    end else begin
                        ctl_d.col = ctl_q.col + 1'b1;
                    end
                end
            end
            S_WAIT: begin
                if (rd_req) begin
                    ctl_d.st  = S_STREAM;
                    ctl_d.ptr = '0;
                    ctl_d.col = '0;
                end
            end
            default: begin
                ctl_d.ovld = 1'b1;
                ctl_d.olbl = lab_mem[ctl_q.ptr];
                ctl_d.oeol = (ctl_q.col == LCOL);
                ctl_d.oeof = (ctl_q.ptr == LAST);
                lab_we     = 1'b1;
                lab_wd     = '0;
                if (ctl_q.ptr == LAST) begin
                    ctl_d.st  = S_LOAD;
                    ctl_d.nxt = LBL_W'(1);
                    ctl_d.row = '0;
                    ctl_d.col = '0;
                    occ_clr   = 1'b1;
                end else begin
                    ctl_d.ptr = ctl_q.ptr + 1'b1;
                    ctl_d.col = (ctl_q.col == LCOL) ? '0 : ctl_q.col + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= S_LOAD;
            ctl_q.nxt <= LBL_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (pix_we) pix_mem[pix_wa] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) lab_mem[i] <= '0;
        end else if (lab_we) begin
            lab_mem[lab_wa] <= lab_wd;
        end
    end

    assign done      = ctl_q.done;
    assign out_valid = ctl_q.ovld;
    assign out_label = ctl_q.olbl;
    assign out_eol   = ctl_q.oeol;
    assign out_eof   = ctl_q.oeof;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_PASS && lab_we && dec == D_NEW) |-> (ctl_q.nxt != SHED)); // R5
    AST_LABEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_PASS && lab_we) |-> (lab_mem[ctl_q.ptr] == '0)); // R2
    AST_LEVEL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_PASS && $past(ctl_q.st) == S_PASS) |-> (ctl_q.lvl == $past(ctl_q.lvl))); // R2
    AST_SHED_TWO_NB: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_PASS && lab_we && dec == D_SHED) |-> ($countones(nb_in) >= 2)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_EOF_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (out_eol && out_valid)); // R9
    AST_EOL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid); // R9
endmodule

// File: tb/sim_wshed_engine.sv
module sim_wshed_engine;
    localparam int W    = 50;
    localparam int H    = 50;
    localparam int NPIX = W * H;
    localparam int SHED = 4095;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_eol = 1'b0;
    logic       in_eof = 1'b0;
    logic       rd_req = 1'b0;
    logic       done, out_valid, out_eol, out_eof;
    logic [11:0] out_label;

    int n_chk = 0;
    int n_bad = 0;
    int img   [NPIX];
    int exp_l [NPIX];
    int got_l [NPIX];

    always #2.5 clk = ~clk;

    wshed_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_eol(in_eol), .in_eof(in_eof), .rd_req(rd_req), .done(done),
        .out_valid(out_valid), .out_label(out_label), .out_eol(out_eol), .out_eof(out_eof)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Independent immersion model: rising levels, raster order, 8-neighbour window
    task automatic run_model();
        int nxt, first, r, c, rr, cc, v;
        bit diff;
        nxt = 1;
        for (int p = 0; p < NPIX; p++) exp_l[p] = 0;
        for (int lv = 0; lv < 256; lv++) begin
            for (int p = 0; p < NPIX; p++) begin
                if (img[p] == lv) begin
                    first = 0; diff = 0; r = p / W; c = p % W;
                    for (int dr = -1; dr <= 1; dr++) begin
                        for (int dc = -1; dc <= 1; dc++) begin
                            rr = r + dr; cc = c + dc;
                            if ((dr != 0 || dc != 0) && rr >= 0 && rr < H && cc >= 0 && cc < W) begin
                                v = exp_l[rr * W + cc];
                                if (v != 0 && v != SHED) begin
                                    if (first == 0) first = v;
                                    else if (v != first) diff = 1;
                                end
                            end
                        end
                    end
                    if (first == 0) begin
                        exp_l[p] = nxt;
                        nxt++;
                    end else if (diff) exp_l[p] = SHED;
                    else exp_l[p] = first;
                end
            end
        end
    endtask

    function automatic int distinct_levels();
        int n;
        bit seen [256];
        n = 0;
        for (int i = 0; i < 256; i++) seen[i] = 0;
        for (int p = 0; p < NPIX; p++) seen[img[p]] = 1;
        for (int i = 0; i < 256; i++) if (seen[i]) n++;
        return n;
    endfunction

    // Load the frame, wait for done, request readout and compare every label
    task automatic run_frame(input string name);
        int cyc, k, tmo, nd;
        bit seen;
        run_model();
        nd = distinct_levels();
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = 8'(img[r * W + c]);
                in_eol   = (c == W - 1);
                in_eof   = (r == H - 1) && (c == W - 1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
        cyc = 1; seen = 0;
        while (!seen && cyc < 40000) begin
            if (done) seen = 1;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk({name, " R8 done seen"}, int'(seen), 1);
        chk({name, " R3 done latency within bound"}, int'(cyc <= nd * NPIX + 260), 1);
        @(negedge clk);
        chk({name, " R8 done is one cycle"}, int'(done), 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk({name, " R8 no output before rd_req"}, int'(out_valid), 0);
        end
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        k = 0; tmo = 0;
        while (k < NPIX && tmo < 3 * NPIX) begin
            @(negedge clk);
            tmo++;
            if (out_valid) begin
                got_l[k] = int'(out_label);
                chk({name, (exp_l[k] == SHED) ? " R6 watershed label" : " R1/R4/R5 region label"},
                    int'(out_label), exp_l[k]);
                chk({name, " R9 out_eol"}, int'(out_eol), int'((k % W) == W - 1));
                chk({name, " R9 out_eof"}, int'(out_eof), int'(k == NPIX - 1));
                k++;
            end else if (k > 0) begin
                chk({name, " R9 stream contiguous"}, 0, 1);
            end
        end
        chk({name, " R9 label count"}, k, NPIX);
        @(negedge clk);
        chk({name, " R9 stream ends"}, int'(out_valid), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lfsr, a, b, g;
        repeat (4) @(negedge clk);
        chk("R8 reset done low", int'(done), 0);
        chk("R9 reset out_valid low", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Two valleys with a ridge between them: watershed line expected
        for (int p = 0; p < NPIX; p++) begin
            a = (p % W) - 12; if (a < 0) a = -a;
            b = (p % W) - 37; if (b < 0) b = -b;
            g = (a < b) ? a : b;
            img[p] = (g / 4) * 30;
        end
        run_frame("two-valley");
        chk("R6 ridge pixel row 0 col 24 or 25 is watershed",
            int'(got_l[24] == SHED || got_l[25] == SHED), 1);
        chk("R5 left valley gets first label", got_l[12], 1);

        // Random three-level frame, lowest and highest grey values included
        lfsr = 32'h1ACE;
        for (int p = 0; p < NPIX; p++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
            lfsr = lfsr & 16'hFFFF;
            img[p] = ((lfsr & 3) == 0) ? 0 : ((lfsr & 3) == 1) ? 255 : 128;
        end
        run_frame("random");

        // Isolated low points: diagonal joins, no wrap between rows
        for (int p = 0; p < NPIX; p++) img[p] = 200;
        img[10 * W + 10] = 0;
        img[11 * W + 11] = 0;
        img[0 * W + 49]  = 0;
        img[1 * W + 0]   = 0;
        run_frame("points");
        chk("R7 diagonal neighbours share a label", got_l[11 * W + 11], got_l[10 * W + 10]);
        chk("R7 row end and next row start are separate regions",
            int'(got_l[1 * W + 0] != got_l[0 * W + 49]), 1);

        // Flat frame after earlier frames: labels restart at 1
        for (int p = 0; p < NPIX; p++) img[p] = 5;
        run_frame("flat");
        chk("R10 fresh frame first label", got_l[0], 1);
        chk("R4 flat frame last pixel inherits", got_l[NPIX - 1], 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule